// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block captures a stream of trace words into an on-chip RAM that is used as a ring. Each valid word is written at the write pointer, which then advances and wraps modulo the RAM depth. Once a word flagged as the trigger has been stored, a programmable post-trigger count sets how many more words are kept before writing stops. Because that count is programmable, software chooses how much of the ring holds history from before the trigger and how much holds what came after it.

Software reaches the block through nine 32-bit registers selected by an index. It clears the write pointer, loads the post-trigger count and then sets the run bit. It polls the status word until acquisition is complete and the input staging has drained. It then points the read pointer at the oldest entry and reads the data register again and again. Each read returns one entry and moves the read pointer forward by one. After a wrap, the oldest entry is the one at the write pointer. Without a wrap, the valid entries run from index 0 up to the write pointer minus one.

Top module: `trace_capture_buf`

## Requirements
- R1: After synchronous reset, status, read pointer, write pointer, post-trigger count and control all read 0, and the output `demux_mode` is 0.
- R2: Index 0 reads the constant identity value (default 32'h7C0B_0001). Index 1 reads the RAM depth and index 2 reads the RAM word width. Writes to these three indices change nothing.
- R3: While the run bit is set and acquisition is not complete, each cycle with `trace_valid` high stores `trace_word` at the write pointer and then advances the pointer by one. With the run bit clear or `trace_valid` low, nothing is stored and the write pointer holds.
- R4: When a word is stored at index DEPTH-1, the write pointer wraps to 0 and status bit 0 (wrapped) is set. The bit stays set until a new run starts. Once it is set, the entry at the write pointer is the oldest one.
- R5: The first stored word that has `trace_trig` high sets status bit 1 (triggered). `trace_trig` has no effect while the run bit is clear.
- R6: After the trigger word, exactly N more words are stored, where N is the post-trigger count. Each of those words decrements the count. When the count reaches 0 (immediately if N is 0), status bit 2 (acquisition done) is set, the count reads 0, and no further word is stored.
- R7: Status bit 3 (drained) becomes 1 two clock cycles after acquisition done rises, and it is never set while acquisition done is clear.
- R8: A read of index 4 returns the entry at the read pointer, zero-extended, and advances the read pointer by one modulo DEPTH. Reads of any other index leave the read pointer unchanged.
- R9: Index 5 (read pointer), index 6 (write pointer) and index 7 (post-trigger count) are writable. A written pointer value is taken modulo DEPTH. A register write wins over a same-cycle update by the block.
- R10: Index 8 is control. Bit 0 is run and bit 1 is demux select, which drives `demux_mode`. Writing 0 stops capture and keeps all status bits. A write that sets run while run is clear starts a new run and clears all four status bits.
- R11: Indices 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_word | input | DATA_W | Trace word to capture |
| trace_valid | input | 1 | trace_word is valid this cycle |
| trace_trig | input | 1 | This word carries the trigger |
| reg_sel | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on index 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel, combinational |
| demux_mode | output | 1 | Demultiplexed port mode selected |

## Verification
The drain-timing property assumes that no new run starts and no reset arrives within the two cycles after acquisition done rises. The bench always inserts idle cycles or reads status before it writes control again. The read-pointer property assumes that a data read is never combined with a read-pointer write, and the single index bus makes that combination impossible. The random rounds load a random start pointer and post-trigger count, then sprinkle valid and trigger pulses. A reference model in the bench predicts pointers, counts and status, and the bench compares against it only after two idle cycles so that the drained bit has settled.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int unsigned REG_W        = 32;
    localparam int unsigned SEL_W        = 4;
    localparam int unsigned DRAIN_CYCLES = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDENT = 4'd0,
        SEL_DEPTH = 4'd1,
        SEL_WIDTH = 4'd2,
        SEL_STAT  = 4'd3,
        SEL_DATA  = 4'd4,
        SEL_RPTR  = 4'd5,
        SEL_WPTR  = 4'd6,
        SEL_TCNT  = 4'd7,
        SEL_CTRL  = 4'd8
    } sel_e;

    // packed MSB first: bit3 drained, bit0 wrapped
    typedef struct packed {
        logic df_empty;
        logic acq_done;
        logic trig_seen;
        logic wrapped;
    } stat_t;

    typedef struct packed {
        logic demux;
        logic run;
    } ctrl_t;

    localparam stat_t STAT_CLEAR = '{default: 1'b0};

    function automatic logic [REG_W-1:0] stat_word(input stat_t s);
        return REG_W'(s);
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [REG_W-1:0] w);
        return ctrl_t'(w[1:0]);
    endfunction

    function automatic logic is_sel(input logic [SEL_W-1:0] s, input sel_e which);
        return s == which;
    endfunction

endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 24,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             tr_valid,
    input  logic             tr_trig,
    input  logic             wptr_we,
    input  logic             tcnt_we,
    input  logic [REG_W-1:0] wdata,
    output logic             store_en,
    output logic [PTR_W-1:0] wptr,
    output logic [REG_W-1:0] tcnt,
    output stat_t            stat
);
    logic [PTR_W-1:0]        wptr_q;
    logic [REG_W-1:0]        tcnt_q;
    logic                    wrapped_q, trig_q, acq_q;
    logic [DRAIN_CYCLES-1:0] drain_q;

    logic trig_word, post_word, at_last;

    assign store_en  = run && tr_valid && !acq_q;
    assign trig_word = store_en && tr_trig && !trig_q;
    assign post_word = store_en && trig_q;
    assign at_last   = wptr_q == PTR_W'(DEPTH - 1);

    // write pointer: register write wins over capture advance
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (wptr_we) begin
            wptr_q <= wdata[PTR_W-1:0];
        end else if (store_en) begin
            wptr_q <= wptr_q + PTR_W'(1);
        end
    end

    // post-trigger down counter
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
        end else if (tcnt_we) begin
            tcnt_q <= wdata;
        end else if (post_word && tcnt_q != '0) begin
            tcnt_q <= tcnt_q - REG_W'(1);
        end
    end

    // status flags
    always_ff @(posedge clk) begin
        if (rst || start) begin
            wrapped_q <= 1'b0;
            trig_q    <= 1'b0;
            acq_q     <= 1'b0;
            drain_q   <= '0;
        end else begin
            if (store_en && at_last) begin
                wrapped_q <= 1'b1;
            end
            if (trig_word) begin
                trig_q <= 1'b1;
                if (tcnt_q == '0) begin
                    acq_q <= 1'b1;
                end
            end
            if (post_word && tcnt_q <= REG_W'(1)) begin
                acq_q <= 1'b1;
            end
            drain_q <= {drain_q[DRAIN_CYCLES-2:0], acq_q};
        end
    end

    assign wptr = wptr_q;
    assign tcnt = tcnt_q;
    always_comb begin
        stat           = STAT_CLEAR;
        stat.wrapped   = wrapped_q;
        stat.trig_seen = trig_q;
        stat.acq_done  = acq_q;
        stat.df_empty  = drain_q[DRAIN_CYCLES-1];
    end
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 24,
    parameter logic [31:0] IDENT  = 32'h7C0B_0001,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    input  stat_t             stat,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [REG_W-1:0]  tcnt,
    input  logic [DATA_W-1:0] ram_q,
    output logic [REG_W-1:0]  rdata,
    output logic [PTR_W-1:0]  rptr,
    output logic              run,
    output logic              demux,
    output logic              start,
    output logic              wptr_we,
    output logic              tcnt_we
);
    ctrl_t            ctrl_q;
    logic [PTR_W-1:0] rptr_q;
    logic             ctrl_we, rptr_we, data_pop;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;

    assign ctrl_we  = wr && is_sel(sel, SEL_CTRL);
    assign rptr_we  = wr && is_sel(sel, SEL_RPTR);
    assign wptr_we  = wr && is_sel(sel, SEL_WPTR);
    assign tcnt_we  = wr && is_sel(sel, SEL_TCNT);
    assign data_pop = rd && is_sel(sel, SEL_DATA);
    assign start    = ctrl_we && wdata[0] && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_decode(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
        end else if (rptr_we) begin
            rptr_q <= wdata[PTR_W-1:0];
        end else if (data_pop) begin
            rptr_q <= rptr_q + PTR_W'(1);
        end
    end

    always_comb begin
        case (sel)
            SEL_IDENT: rdata = IDENT;
            SEL_DEPTH: rdata = REG_W'(DEPTH);
            SEL_WIDTH: rdata = REG_W'(DATA_W);
            SEL_STAT:  rdata = stat_word(stat);
            SEL_DATA:  rdata = REG_W'(ram_q);
            SEL_RPTR:  rdata = REG_W'(rptr_q);
            SEL_WPTR:  rdata = REG_W'(wptr);
            SEL_TCNT:  rdata = tcnt;
            SEL_CTRL:  rdata = REG_W'(ctrl_q);
            default:   rdata = '0;
        endcase
    end

    assign rptr  = rptr_q;
    assign run   = ctrl_q.run;
    assign demux = ctrl_q.demux;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 24,
    parameter logic [31:0] IDENT  = 32'h7C0B_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] trace_word,
    input  logic              trace_valid,
    input  logic              trace_trig,
    input  logic [3:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              demux_mode
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]  wptr, rptr;
    logic [REG_W-1:0]  tcnt;
    logic [DATA_W-1:0] ram_q;
    stat_t             stat;
    logic              ctrl_run, start, wptr_we, tcnt_we, store_en;

    tcb_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDENT(IDENT)) u_regs (
        .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .stat(stat), .wptr(wptr), .tcnt(tcnt),
        .ram_q(ram_q), .rdata(reg_rdata), .rptr(rptr), .run(ctrl_run),
        .demux(demux_mode), .start(start), .wptr_we(wptr_we), .tcnt_we(tcnt_we)
    );

    tcb_capture #(.DEPTH(DEPTH)) u_capture (
        .clk(clk), .rst(rst), .run(ctrl_run), .start(start),
        .tr_valid(trace_valid), .tr_trig(trace_trig), .wptr_we(wptr_we),
        .tcnt_we(tcnt_we), .wdata(reg_wdata), .store_en(store_en),
        .wptr(wptr), .tcnt(tcnt), .stat(stat)
    );

    tcb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(store_en), .wr_addr(wptr), .wr_data(trace_word),
        .rd_addr(rptr), .rd_data(ram_q)
    );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             trace_valid,
    input logic             wptr_we,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr,
    input stat_t            stat,
    input logic             reg_rd,
    input logic [3:0]       reg_sel
);
    assert_wptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((!(run && trace_valid) || stat.acq_done) && !wptr_we) |=> $stable(wptr));

    assert_full_from_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.wrapped) |-> ($past(wptr) == PTR_W'(DEPTH - 1)));

    assert_acq_needs_trig_R6: assert property (@(posedge clk) disable iff (rst)
        stat.acq_done |-> stat.trig_seen);

    assert_drain_delay_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.acq_done) |-> ##2 stat.df_empty);

    assert_drain_needs_acq_R7: assert property (@(posedge clk) disable iff (rst)
        stat.df_empty |-> stat.acq_done);

    assert_rptr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == 4'd4) |=> (rptr == PTR_W'($past(rptr) + 1)));
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tcb_checker (
    .clk(clk), .rst(rst), .run(ctrl_run), .trace_valid(trace_valid),
    .wptr_we(wptr_we), .wptr(wptr), .rptr(rptr), .stat(stat),
    .reg_rd(reg_rd), .reg_sel(reg_sel)
);

// File: tb/test_trace_capture_buf.sv
`timescale 1ns/1ps
module test_trace_capture_buf;
    localparam int D = 64;
    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  trace_word = '0;
    logic          trace_valid = 1'b0, trace_trig = 1'b0;
    logic [3:0]    reg_sel = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          demux_mode;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model
    logic [W-1:0] mem [D];
    int  mw = 0, mr = 0, mt = 0;
    bit  m_en = 0, m_full = 0, m_trg = 0, m_acq = 0;

    trace_capture_buf i_trace_capture_buf (
        .clk(clk), .rst(rst), .trace_word(trace_word), .trace_valid(trace_valid),
        .trace_trig(trace_trig), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .demux_mode(demux_mode)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] v);
        reg_sel = idx[3:0]; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        case (idx)
            5: mr = int'(v % D);
            6: mw = int'(v % D);
            7: mt = int'(v);
            8: begin
                if (v[0] && !m_en) begin m_full = 0; m_trg = 0; m_acq = 0; end
                m_en = v[0];
            end
            default: ;
        endcase
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        reg_sel = idx[3:0]; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        if (idx == 4) mr = (mr + 1) % D;
    endtask

    task automatic peek(input int idx, output logic [31:0] v);
        reg_sel = idx[3:0];
        #1 v = reg_rdata;
    endtask

    task automatic drive(input bit v, input logic [W-1:0] d, input bit t);
        trace_valid = v; trace_word = d; trace_trig = t;
        @(posedge clk); #1;
        trace_valid = 1'b0; trace_trig = 1'b0;
        if (m_en && v && !m_acq) begin
            mem[mw] = d;
            if (mw == D - 1) m_full = 1;
            mw = (mw + 1) % D;
            if (m_trg) begin
                if (mt <= 1) m_acq = 1;
                if (mt != 0) mt--;
            end else if (t) begin
                m_trg = 1;
                if (mt == 0) m_acq = 1;
            end
        end
    endtask

    function automatic logic [31:0] mstat(input bit drained);
        return {28'd0, drained & m_acq, m_acq, m_trg, m_full};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        peek(3, v); chk("R1 status", v, 0);
        peek(5, v); chk("R1 rptr", v, 0);
        peek(6, v); chk("R1 wptr", v, 0);
        peek(7, v); chk("R1 tcnt", v, 0);
        peek(8, v); chk("R1 ctrl", v, 0);
        chk("R1 demux", {31'd0, demux_mode}, 0);

        // R2 constants, read-only
        wr_reg(0, 32'hFFFF_FFFF); wr_reg(1, 32'd5); wr_reg(2, 32'd7);
        peek(0, v); chk("R2 ident", v, 32'h7C0B_0001);
        peek(1, v); chk("R2 depth", v, D);
        peek(2, v); chk("R2 width", v, W);

        // R11 unused indices
        for (int i = 9; i < 16; i++) begin
            wr_reg(i, 32'hA5A5_A5A5);
            peek(i, v); chk("R11 unused index reads 0", v, 0);
        end
        peek(8, v); chk("R11 ctrl untouched", v, 0);

        // R3/R5 disabled: no store, trigger ignored
        drive(1, 24'h123456, 1); drive(1, 24'h654321, 0);
        peek(6, v); chk("R3 no store while disabled", v, 0);
        peek(3, v); chk("R5 trig ignored while disabled", v, 0);

        // R3/R8 random capture, then read back
        wr_reg(7, 1000); wr_reg(6, 0); wr_reg(8, 1);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            bit vb = ($urandom % 3) != 0;
            drive(vb, W'($urandom), 0);
            if (vb) n++;
        end
        peek(6, v); chk("R3 wptr counts stored words", v, n);
        wr_reg(5, 0);
        for (int i = 0; i < n; i++) begin
            rd_reg(4, v); chk("R8 data readback", v, 32'(mem[i]));
        end
        peek(5, v); chk("R8 rptr advanced", v, n % D);
        rd_reg(6, v); peek(5, v); chk("R8 non-data read keeps rptr", v, n % D);

        // R4 wrap and oldest-first order
        for (int i = 0; i < D; i++) drive(1, W'($urandom), 0);
        peek(3, v); chk("R4 wrapped bit", v, 32'd1);
        peek(6, v); chk("R4 wptr after wrap", v, mw);
        wr_reg(5, mw);
        for (int i = 0; i < D; i++) begin
            rd_reg(4, v); chk("R4 oldest-first readback", v, 32'(mem[(mw + i) % D]));
        end

        // R10 stop keeps status
        wr_reg(8, 0);
        drive(1, 24'h0BAD00, 1);
        peek(6, v); chk("R10 stopped: wptr holds", v, mw);
        peek(3, v); chk("R10 stopped: status kept", v, 32'd1);

        // R10 new run clears status, demux bit
        wr_reg(7, 5); wr_reg(6, 0); wr_reg(8, 3);
        peek(3, v); chk("R10 new run clears status", v, 0);
        peek(8, v); chk("R10 ctrl readback", v, 3);
        chk("R10 demux port", {31'd0, demux_mode}, 1);

        // R6/R7 trigger at word 3, five more words
        for (int i = 0; i < 9; i++) drive(1, W'($urandom), i == 3);
        peek(3, v); chk("R6 acq done, R7 not drained yet", v, 32'h6);
        drive(0, 0, 0);
        peek(3, v); chk("R7 one cycle after acq", v, 32'h6);
        drive(0, 0, 0);
        peek(3, v); chk("R7 drained two cycles after acq", v, 32'hE);
        drive(1, 1, 0); drive(1, 2, 0);
        peek(6, v); chk("R6 stores stop after count", v, 9);
        peek(7, v); chk("R6 count reaches 0", v, 0);

        // R6 zero count: trigger word is the last stored
        wr_reg(8, 0); wr_reg(7, 0); wr_reg(6, 10); wr_reg(8, 1);
        for (int i = 0; i < 4; i++) drive(1, W'($urandom), i == 1);
        peek(6, v); chk("R6 zero count stops at trigger word", v, 12);

        // random rounds against the model
        for (int r = 0; r < 4; r++) begin
            wr_reg(8, 0); wr_reg(7, $urandom % 20); wr_reg(6, $urandom); wr_reg(8, 1);
            for (int i = 0; i < 60; i++)
                drive(($urandom % 4) != 0, W'($urandom), ($urandom % 15) == 0);
            drive(0, 0, 0); drive(0, 0, 0);
            peek(3, v); chk("R5 R6 R7 random status", v, mstat(1));
            peek(6, v); chk("R3 R4 random wptr", v, mw);
            peek(7, v); chk("R6 random count", v, mt);
        end

        // R9 writable registers, modulo depth
        wr_reg(8, 0);
        wr_reg(5, D + 5); peek(5, v); chk("R9 rptr modulo", v, 5);
        wr_reg(6, 2 * D + 2); peek(6, v); chk("R9 wptr modulo", v, 2);
        wr_reg(7, 32'h1234); peek(7, v); chk("R9 tcnt write", v, 32'h1234);

        // R8 read pointer wrap
        wr_reg(5, D - 1);
        rd_reg(4, v); chk("R8 read at last index", v, 32'(mem[D-1]));
        rd_reg(4, v); chk("R8 read after wrap", v, 32'(mem[0]));
        peek(5, v); chk("R8 rptr wraps", v, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule